// File: doc/BRIEF.md
# Asymmetric Input Debounce Filter

This block cleans up one noisy input pin before its level reaches the logic that uses it. The pin first goes through a two-flop synchroniser. A change on the synchronised pin opens a sampling session. For the rest of that session, each pulse on the periodic tick input is one check of the pin against the stored debounced state. A change is accepted only after the pin has disagreed with the stored state on a set number of consecutive checks. The number of checks for a rising change and for a falling change are separate parameters, so the two directions can be qualified differently.

When a change is accepted, the session ends and the filter waits for the next edge. The accepted change can also raise a one-cycle event. In the default mode the event fires only when the new state is the active level. With either-edge reporting enabled, it fires on every accepted change. A mode pin makes low the active level, and the level presented to the consumer is corrected for that polarity.

The tick is usually one pulse per millisecond from a shared timebase. With the defaults, a change must therefore hold for about 2 ms in either direction.

Top module: `asym_debounce`

## Requirements
- R1: The raw pin passes through two synchroniser flops. A sampling session opens on the third rising clock edge after the pin changes, and a tick that comes before that edge has no effect.
- R2: After reset, the stored state is 0, no session is open, `event_o` is 0 and `level_o` equals `active_low_i`.
- R3: Checks happen only on clock edges where `tick_i` is 1 and a session is open. With no session open, ticks leave the outputs unchanged.
- R4: A check that finds the synchronised pin equal to the stored state reloads the counter, so a disagreement shorter than the hold time is discarded.
- R5: A check that finds the pin different from the stored state decrements the counter. The new state is committed on the RISE_TICKS-th consecutive differing check for a 0-to-1 change, and on the FALL_TICKS-th for a 1-to-0 change.
- R6: `event_o` is 1 for exactly the one cycle after a committing edge. It is raised only if the new state equals the active level, or if `both_edges_i` is 1. The active level is 1 when `active_low_i` is 0, and 0 when `active_low_i` is 1.
- R7: A commit closes the session. A pin edge that arrives while a session is open neither restarts nor extends it.
- R8: `level_o` is the stored state, inverted when `active_low_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | 1 | Unsynchronised pin level |
| tick_i | input | 1 | One-cycle check strobe from the timebase |
| active_low_i | input | 1 | 1 makes low the active level and inverts `level_o` |
| both_edges_i | input | 1 | 1 raises an event on every accepted change |
| level_o | output | 1 | Debounced, polarity-corrected level |
| event_o | output | 1 | One-cycle pulse on an accepted change that qualifies |

## Verification
Most internal faults show up at the ports within a few ticks:
- A counter that is not reloaded on an agreeing check lets a glitch through. `level_o` then flips one or two ticks too early.
- A wrong reload value shifts the commit by a whole tick in one direction only. For this reason the two directions are run with different counts.
- A session flag that fails to clear or to set shows up as a missing commit or a spurious one.
- An inverted event qualifier shows up as `event_o` on the wrong edge, in the cycle right after the commit.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  typedef enum logic {
    SES_IDLE = 1'b0,
    SES_RUN  = 1'b1
  } ses_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic smp_o,
  output logic edge_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], raw_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign smp_o  = chain_q[STAGES-1];
  assign edge_o = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/dbnc_core.sv
module dbnc_core
  import dbnc_pkg::*;
#(
  parameter int RISE_TICKS = 2,
  parameter int FALL_TICKS = 2,
  parameter int CNT_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             edge_i,
  input  logic             tick_i,
  output logic             state_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             commit_o
);

  localparam logic [CNT_W-1:0] RISE_LD = CNT_W'(RISE_TICKS);
  localparam logic [CNT_W-1:0] FALL_LD = CNT_W'(FALL_TICKS);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  ses_e             ses_q;
  logic             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differ;

  // reload count for leaving the given state
  function automatic logic [CNT_W-1:0] reload(input logic cur);
    return cur ? FALL_LD : RISE_LD;
  endfunction

  assign differ   = smp_i != state_q;
  assign commit_o = (ses_q == SES_RUN) && tick_i && differ && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ses_q   <= SES_IDLE;
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (ses_q)
        SES_IDLE: begin
          if (edge_i) begin
            ses_q <= SES_RUN;
            cnt_q <= reload(state_q);
          end
        end
        default: begin
          if (tick_i) begin
            if (!differ) begin
              cnt_q <= reload(state_q);
            end else if (cnt_q == ONE) begin
              state_q <= smp_i;
              cnt_q   <= reload(smp_i);
              ses_q   <= SES_IDLE;
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign busy_o  = (ses_q == SES_RUN);
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/dbnc_report.sv
module dbnc_report (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic new_state_i,
  input  logic state_i,
  input  logic active_low_i,
  input  logic both_edges_i,
  output logic event_o,
  output logic level_o
);

  logic wanted;
  logic event_q;

  assign wanted = both_edges_i | (new_state_i ^ active_low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) event_q <= 1'b0;
    else         event_q <= commit_i & wanted;
  end

  assign event_o = event_q;
  assign level_o = state_i ^ active_low_i;

endmodule

// File: rtl/asym_debounce.sv
module asym_debounce
  import dbnc_pkg::*;
#(
  parameter int RISE_TICKS  = 2,
  parameter int FALL_TICKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic tick_i,
  input  logic active_low_i,
  input  logic both_edges_i,
  output logic level_o,
  output logic event_o
);

  localparam int MAX_LD = max_of(RISE_TICKS, FALL_TICKS);
  localparam int CNT_W  = $clog2(MAX_LD + 1);

  logic             smp_w;
  logic             edge_w;
  logic             state_w;
  logic             busy_w;
  logic [CNT_W-1:0] cnt_w;
  logic             commit_w;

  dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_i),
    .smp_o  (smp_w),
    .edge_o (edge_w)
  );

  dbnc_core #(
    .RISE_TICKS (RISE_TICKS),
    .FALL_TICKS (FALL_TICKS),
    .CNT_W      (CNT_W)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_i    (smp_w),
    .edge_i   (edge_w),
    .tick_i   (tick_i),
    .state_o  (state_w),
    .busy_o   (busy_w),
    .cnt_o    (cnt_w),
    .commit_o (commit_w)
  );

  dbnc_report u_report (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit_w),
    .new_state_i  (smp_w),
    .state_i      (state_w),
    .active_low_i (active_low_i),
    .both_edges_i (both_edges_i),
    .event_o      (event_o),
    .level_o      (level_o)
  );

endmodule

// File: rtl/asym_debounce_chk.sv
module asym_debounce_chk #(
  parameter int MAX_LD = 2,
  parameter int CNT_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             smp_i,
  input logic             state_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             event_i
);

  // R3: stored state moves only on a tick edge
  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (state_i == $past(state_i)));

  // R5: a committed state is the synchronised sample seen at that edge
  a_r5_commit_takes_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != $past(state_i)) |-> (state_i == $past(smp_i)));

  // R5: counter stays within its loaded range during a session
  a_r5_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (cnt_i != '0 && int'(cnt_i) <= MAX_LD));

  // R6: an event only accompanies a state change
  a_r6_event_marks_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |-> (state_i != $past(state_i)));

  // R7: a commit closes the session
  a_r7_idle_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != $past(state_i)) |-> !busy_i);

endmodule

bind asym_debounce asym_debounce_chk #(
  .MAX_LD (MAX_LD),
  .CNT_W  (CNT_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .smp_i   (smp_w),
  .state_i (state_w),
  .busy_i  (busy_w),
  .cnt_i   (cnt_w),
  .event_i (event_o)
);

// File: tb/test_asym_debounce.sv
`timescale 1ns/1ps
module test_asym_debounce;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw = 1'b0;
  logic tick = 1'b0;
  logic act_low = 1'b0;
  logic both = 1'b0;
  logic level;
  logic evt;
  int   n_chk = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  asym_debounce #(.RISE_TICKS(2), .FALL_TICKS(3)) i_asym_debounce (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .raw_i        (raw),
    .tick_i       (tick),
    .active_low_i (act_low),
    .both_edges_i (both),
    .level_o      (level),
    .event_o      (evt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 level", level, 1'b0);
    chk("R2 event", evt, 1'b0);
    act_low = 1'b1;
    #1;
    chk("R8 inverted at reset", level, 1'b1);
    act_low = 1'b0;
    #1;
  endtask

  task automatic t_rise;
    raw = 1'b1;
    pulse;                 // too early: session not open yet (R1)
    idle(4);
    pulse;
    chk("R1 early tick ignored", level, 1'b0);
    chk("R6 no event before commit", evt, 1'b0);
    pulse;
    chk("R5 rise after 2 checks", level, 1'b1);
    chk("R6 event on active rise", evt, 1'b1);
    idle(1);
    chk("R6 single cycle pulse", evt, 1'b0);
  endtask

  task automatic t_fall_bounce;
    raw = 1'b0; idle(4);
    pulse;
    raw = 1'b1; idle(4);
    pulse;                 // agrees: reload
    raw = 1'b0; idle(4);   // edge inside running session (R7)
    pulse; pulse;
    chk("R4 reload after agreement", level, 1'b1);
    pulse;
    chk("R5 fall after 3 checks", level, 1'b0);
    chk("R6 no event on inactive edge", evt, 1'b0);
  endtask

  task automatic t_glitch;
    raw = 1'b1; idle(4);
    pulse;
    raw = 1'b0; idle(4);
    pulse; pulse; pulse;
    chk("R4 glitch rejected", level, 1'b0);
    chk("R4 glitch no event", evt, 1'b0);
    raw = 1'b1; idle(4);
    pulse;
    chk("R7 session not restarted", level, 1'b0);
    pulse;
    chk("R7 commit in running session", level, 1'b1);
    chk("R6 event on rise", evt, 1'b1);
  endtask

  task automatic t_idle_ticks;
    idle(2);
    for (int i = 0; i < 4; i++) begin
      pulse;
      chk("R3 idle tick no change", level, 1'b1);
      chk("R3 idle tick no event", evt, 1'b0);
    end
  endtask

  task automatic t_both;
    both = 1'b1;
    raw = 1'b0; idle(4);
    pulse; pulse;
    chk("R5 fall needs third check", level, 1'b1);
    pulse;
    chk("R5 fall commit", level, 1'b0);
    chk("R6 both-edge event on fall", evt, 1'b1);
    raw = 1'b1; idle(4);
    pulse; pulse;
    chk("R5 rise commit", level, 1'b1);
    chk("R6 both-edge event on rise", evt, 1'b1);
    both = 1'b0;
    idle(1);
  endtask

  task automatic t_active_low;
    act_low = 1'b1;
    #1;
    chk("R8 high state reads low", level, 1'b0);
    idle(1);
    raw = 1'b0; idle(4);
    pulse; pulse; pulse;
    chk("R8 low state reads high", level, 1'b1);
    chk("R6 active-low event on fall", evt, 1'b1);
    raw = 1'b1; idle(4);
    pulse; pulse;
    chk("R8 back to low", level, 1'b0);
    chk("R6 no active-low event on rise", evt, 1'b0);
    act_low = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_rise;
    t_fall_bounce;
    t_glitch;
    t_idle_ticks;
    t_both;
    t_active_low;
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule